// File: doc/BRIEF.md
# Segmented Current-Steering DAC Element Decoder

This block is the digital front end of a 10-bit current-steering converter. On every rising clock edge it takes in a parallel binary sample. It splits the sample into three segments of decreasing weight:

- the five most significant bits become a unary (thermometer) code over 31 equal upper elements;
- the next four bits become a unary code over 15 equal middle elements, each weighing one sixteenth of an upper element;
- the least significant bit drives a single binary-weighted element.

Every element gets a pair of steering controls. One sends its current to the true output and the other sends it to the complementary output. A second register stage holds the decoded controls, so every control changes on the same clock edge.

An active-high sleep input turns every element off, so that neither output carries current. The sleep input travels through the same two register stages as the data, so it takes effect with the same latency as a code change. Both register stages clear to code 0 with sleep off under a synchronous active-low reset.

Top module: `segdac_front`

## Requirements
- R1: A code applied to `code_in` before a rising edge is captured on that edge and appears on the element controls after the following rising edge (fixed 2-cycle latency); after only one edge the controls still show the previous code.
- R2: With U = `code_in[9:5]`, upper element k (0..30) steers to the true side exactly when U > k, so the upper controls fill from index 0 upward.
- R3: With M = `code_in[4:1]`, middle element k (0..14) steers to the true side exactly when M > k.
- R4: `code_in[0]` alone drives the single low element's true control.
- R5: Counting 32 per upper element, 2 per middle element and 1 for the low element, the true-side controls that are on add up to the captured code for every code from 0 to 1023.
- R6: While awake, every complementary control is the exact inverse of its true control. Code 1023 puts all elements on the true side and code 0 puts all elements on the complementary side.
- R7: Sleep is active high and has the same 2-cycle latency as data. While it is in effect, every true and every complementary control is low. After sleep is released, the held code reappears two edges later.
- R8: When `rst_n` is low at a rising edge, both register stages clear to code 0 with sleep off. All true controls then read 0 and all complementary controls read 1.
- R9: When the captured code and sleep do not change, no element control changes; all controls update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising-edge active, up to 125 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | 10 | Unsigned binary sample, bit 9 most significant |
| sleep_in | input | 1 | Active-high power-down; turns every element off |
| up_true | output | 31 | Upper elements steered to the true output |
| up_comp | output | 31 | Upper elements steered to the complementary output |
| mid_true | output | 15 | Middle elements steered to the true output |
| mid_comp | output | 15 | Middle elements steered to the complementary output |
| lo_true | output | 1 | Low element steered to the true output |
| lo_comp | output | 1 | Low element steered to the complementary output |

## Verification
The assertions check four properties on every cycle against a two-stage model of the inputs:

- the weighted element count matches the delayed code;
- the upper and middle controls are proper thermometer patterns;
- each complementary control is the inverse of its true control, and both are low in sleep;
- the controls hold still while the delayed code and sleep are unchanged.

The exact latency needs the bench's scenarios: the controls must still show the old value after one edge. So do the entry into and exit from sleep, a reset in the middle of a stream, and the outputs for each of the 1024 codes in a streamed sweep.

// File: rtl/segdac_pkg.sv
// Package: shared segmentation defaults and helpers for the element decoder.
// Assumes segment widths are small enough that 2**w - 1 elements fit an int.
package segdac_pkg;

    // Default segment widths: upper unary, middle unary, low binary.
    localparam int SEG_UPPER_W = 5;
    localparam int SEG_MID_W   = 4;
    localparam int SEG_LOW_W   = 1;

    // Number of unary elements needed for a segment of w bits.
    function automatic int unary_elems(input int w);
        return (1 << w) - 1;
    endfunction

    // Weight in LSB units of one element of a segment at bit offset pos.
    function automatic int elem_weight(input int pos);
        return 1 << pos;
    endfunction

endpackage

// File: rtl/segdac_capture.sv
// Module: input capture stage.
// Registers the binary sample and the sleep request on the rising edge.
// Assumes a synchronous active-low reset that clears to code 0, awake.
module segdac_capture #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              sleep_in,
    output logic [CODE_W-1:0] code_q,
    output logic              sleep_q
);

    // Capture the sample and the sleep request together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            sleep_q <= 1'b0;
        end else begin
            code_q  <= code_in;
            sleep_q <= sleep_in;
        end
    end

endmodule

// File: rtl/segdac_unary.sv
// Module: binary-to-unary segment decoder.
// Element k of the output is set exactly when the segment value exceeds k,
// so the elements fill from index 0 upward. Purely combinational.
// Assumes SEG_W >= 1.
module segdac_unary #(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0]        seg_val,
    output logic [(1<<SEG_W)-2:0]   therm
);

    localparam int N_ELEM = (1 << SEG_W) - 1;

    // One comparator per element; the structure repeats N_ELEM times.
    for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
        localparam logic [SEG_W:0] K_VAL = (SEG_W+1)'(k);
        assign therm[k] = ({1'b0, seg_val} > K_VAL);
    end

endmodule

// File: rtl/segdac_drive.sv
// Module: element steering register for one segment.
// Registers the decoded true-side pattern and its complement so every
// element switches on the same edge. While off_req is high, both sides are
// cleared. Reset leaves every element on the complementary side (code 0).
// Assumes the decoded pattern arrives one cycle after input capture.
module segdac_drive #(
    parameter int N_ELEM = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ELEM-1:0] dec_true,
    input  logic              off_req,
    output logic [N_ELEM-1:0] drv_true,
    output logic [N_ELEM-1:0] drv_comp
);

    logic [N_ELEM-1:0] nxt_true;
    logic [N_ELEM-1:0] nxt_comp;

    // Per-element steering choice, gated by the sleep request.
    for (genvar e = 0; e < N_ELEM; e++) begin : g_steer
        always_comb begin
            nxt_true[e] = dec_true[e] & ~off_req;
            nxt_comp[e] = ~dec_true[e] & ~off_req;
        end
    end

    // Output register: all elements of the segment update together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_true <= '0;
            drv_comp <= '1;
        end else begin
            drv_true <= nxt_true;
            drv_comp <= nxt_comp;
        end
    end

endmodule

// File: rtl/segdac_front.sv
// Module: segmented current-steering DAC element decoder (top).
// Captures a binary code, splits it into upper unary, middle unary and low
// binary segments, and registers one true/complement steering pair per
// element. Sleep forces every pair low. Latency from capture is 2 cycles.
// Assumes a synchronous active-low reset; sleep reads as off after reset.
module segdac_front
    import segdac_pkg::*;
#(
    parameter int UPPER_W = SEG_UPPER_W,
    parameter int MID_W   = SEG_MID_W,
    parameter int LOW_W   = SEG_LOW_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [UPPER_W+MID_W+LOW_W-1:0] code_in,
    input  logic                        sleep_in,
    output logic [(1<<UPPER_W)-2:0]     up_true,
    output logic [(1<<UPPER_W)-2:0]     up_comp,
    output logic [(1<<MID_W)-2:0]       mid_true,
    output logic [(1<<MID_W)-2:0]       mid_comp,
    output logic [LOW_W-1:0]            lo_true,
    output logic [LOW_W-1:0]            lo_comp
);

    localparam int CODE_W  = UPPER_W + MID_W + LOW_W;
    localparam int UP_N    = (1 << UPPER_W) - 1;
    localparam int MID_N   = (1 << MID_W) - 1;
    localparam int UP_LSB  = MID_W + LOW_W;
    localparam int MID_LSB = LOW_W;

    logic [CODE_W-1:0]  code_q;
    logic               sleep_q;
    logic [UPPER_W-1:0] up_field;
    logic [MID_W-1:0]   mid_field;
    logic [LOW_W-1:0]   low_field;
    logic [UP_N-1:0]    up_dec;
    logic [MID_N-1:0]   mid_dec;

    // Stage 1: capture sample and sleep request.
    segdac_capture #(.CODE_W(CODE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_in  (code_in),
        .sleep_in (sleep_in),
        .code_q   (code_q),
        .sleep_q  (sleep_q)
    );

    // Split the captured code into its three segments.
    always_comb begin
        up_field  = code_q[CODE_W-1:UP_LSB];
        mid_field = code_q[UP_LSB-1:MID_LSB];
        low_field = code_q[LOW_W-1:0];
    end

    // Unary decoders for the upper and middle segments.
    segdac_unary #(.SEG_W(UPPER_W)) u_dec_up (
        .seg_val (up_field),
        .therm   (up_dec)
    );

    segdac_unary #(.SEG_W(MID_W)) u_dec_mid (
        .seg_val (mid_field),
        .therm   (mid_dec)
    );

    // Stage 2: steering registers, one per segment.
    segdac_drive #(.N_ELEM(UP_N)) u_drv_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_true (up_dec),
        .off_req  (sleep_q),
        .drv_true (up_true),
        .drv_comp (up_comp)
    );

    segdac_drive #(.N_ELEM(MID_N)) u_drv_mid (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_true (mid_dec),
        .off_req  (sleep_q),
        .drv_true (mid_true),
        .drv_comp (mid_comp)
    );

    segdac_drive #(.N_ELEM(LOW_W)) u_drv_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_true (low_field),
        .off_req  (sleep_q),
        .drv_true (lo_true),
        .drv_comp (lo_comp)
    );

endmodule

// File: rtl/segdac_front_chk.sv
// Module: property checker for segdac_front, attached by bind.
// Keeps its own two-stage delay of the inputs and relates the element
// controls to it on every cycle.
module segdac_front_chk #(
    parameter int UPPER_W = 5,
    parameter int MID_W   = 4,
    parameter int LOW_W   = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [UPPER_W+MID_W+LOW_W-1:0] code_in,
    input logic                           sleep_in,
    input logic [(1<<UPPER_W)-2:0]        up_true,
    input logic [(1<<UPPER_W)-2:0]        up_comp,
    input logic [(1<<MID_W)-2:0]          mid_true,
    input logic [(1<<MID_W)-2:0]          mid_comp,
    input logic [LOW_W-1:0]               lo_true,
    input logic [LOW_W-1:0]               lo_comp
);

    localparam int CODE_W = UPPER_W + MID_W + LOW_W;
    localparam int W_UP   = 1 << (MID_W + LOW_W);
    localparam int W_MID  = 1 << LOW_W;

    logic [CODE_W-1:0] c1, c2;
    logic              s1, s2;
    int                wsum;

    // Two-cycle delay model of code and sleep, cleared like the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1 <= '0; c2 <= '0; s1 <= 1'b0; s2 <= 1'b0;
        end else begin
            c1 <= code_in; c2 <= c1; s1 <= sleep_in; s2 <= s1;
        end
    end

    // Weighted total of true-side elements.
    always_comb wsum = $countones(up_true) * W_UP + $countones(mid_true) * W_MID
                       + int'(lo_true);

    // R5
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s2 |-> (wsum == int'(c2)));

    // R2
    up_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_true & (up_true + 1'b1)) == '0));

    // R3
    mid_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mid_true & (mid_true + 1'b1)) == '0));

    // R6
    comp_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s2 |-> (up_comp == ~up_true && mid_comp == ~mid_true && lo_comp == ~lo_true));

    // R7
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2 |-> (up_true == '0 && up_comp == '0 && mid_true == '0 && mid_comp == '0
                && lo_true == '0 && lo_comp == '0));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c2 == $past(c2) && s2 == $past(s2)) |->
        ($stable(up_true) && $stable(up_comp) && $stable(mid_true) && $stable(mid_comp)
         && $stable(lo_true) && $stable(lo_comp)));

endmodule

bind segdac_front segdac_front_chk #(
    .UPPER_W (UPPER_W),
    .MID_W   (MID_W),
    .LOW_W   (LOW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_in  (code_in),
    .sleep_in (sleep_in),
    .up_true  (up_true),
    .up_comp  (up_comp),
    .mid_true (mid_true),
    .mid_comp (mid_comp),
    .lo_true  (lo_true),
    .lo_comp  (lo_comp)
);

// File: tb/sim_segdac_front.sv
// Directed bench for segdac_front; one task per scenario.
module sim_segdac_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  code_in = '0;
    logic        sleep_in = 1'b0;
    logic [30:0] up_true, up_comp;
    logic [14:0] mid_true, mid_comp;
    logic [0:0]  lo_true, lo_comp;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    segdac_front u0 (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .sleep_in(sleep_in),
        .up_true(up_true), .up_comp(up_comp), .mid_true(mid_true),
        .mid_comp(mid_comp), .lo_true(lo_true), .lo_comp(lo_comp)
    );

    // Compare all controls with the expected pattern for a code and sleep.
    task automatic check_out(input string tag, input int code, input bit slp);
        logic [30:0] eu;
        logic [14:0] em;
        logic        el;
        eu = '0; em = '0;
        for (int k = 0; k < 31; k++) eu[k] = ((code >> 5) > k);
        for (int k = 0; k < 15; k++) em[k] = (((code >> 1) & 15) > k);
        el = code[0];
        n_checks++;
        if (slp ? (up_true !== '0 || up_comp !== '0 || mid_true !== '0 ||
                   mid_comp !== '0 || lo_true !== 1'b0 || lo_comp !== 1'b0)
                : (up_true !== eu || up_comp !== ~eu || mid_true !== em ||
                   mid_comp !== ~em || lo_true !== el || lo_comp !== ~el)) begin
            n_errors++;
            $display("FAIL %s code=%0d sleep=%0b: got up=%h/%h mid=%h/%h lo=%b/%b exp up=%h mid=%h lo=%b (comp inverse, zeros if sleep)",
                     tag, code, slp, up_true, up_comp, mid_true, mid_comp,
                     lo_true, lo_comp, eu, em, el);
        end
    endtask

    // Drive at the falling edge, wait two rising edges, check.
    task automatic apply(input int code, input bit slp);
        @(negedge clk);
        code_in = 10'(code);
        sleep_in = slp;
        @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    // R8: reset state is code 0, awake.
    task automatic t_reset();
        rst_n = 1'b0;
        code_in = 10'd777;
        sleep_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_out("R8 reset", 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R6: full-scale and zero codes.
    task automatic t_extremes();
        apply(1023, 1'b0); check_out("R6 all-ones", 1023, 1'b0);
        apply(0, 1'b0);    check_out("R6 all-zero", 0, 1'b0);
    endtask

    // R2 R3 R4: segment boundaries.
    task automatic t_boundaries();
        apply(32, 1'b0);  check_out("R2 first upper", 32, 1'b0);
        apply(31, 1'b0);  check_out("R3 mid full low set", 31, 1'b0);
        apply(1, 1'b0);   check_out("R4 low only", 1, 1'b0);
        apply(2, 1'b0);   check_out("R3 first mid", 2, 1'b0);
        apply(992, 1'b0); check_out("R2 upper full", 992, 1'b0);
    endtask

    // R1: after one edge the old code is still shown; after two, the new one.
    task automatic t_latency();
        apply(100, 1'b0);
        @(negedge clk);
        code_in = 10'd613;
        @(posedge clk); #1;
        check_out("R1 one edge keeps old", 100, 1'b0);
        @(posedge clk); #1;
        check_out("R1 two edges new", 613, 1'b0);
    endtask

    // R5 R1: streamed sweep of every code, one per cycle.
    task automatic t_sweep();
        for (int i = 0; i < 1026; i++) begin
            @(negedge clk);
            if (i >= 2) check_out("R5 sweep", i - 2, 1'b0);
            if (i < 1024) code_in = 10'(i);
        end
    endtask

    // R7: sleep entry, latency, and release.
    task automatic t_sleep();
        apply(700, 1'b0);
        @(negedge clk);
        sleep_in = 1'b1;
        @(posedge clk); #1;
        check_out("R7 sleep one edge still awake", 700, 1'b0);
        @(posedge clk); #1;
        check_out("R7 sleep off", 700, 1'b1);
        apply(1023, 1'b1);
        check_out("R7 sleep ignores code", 1023, 1'b1);
        @(negedge clk);
        sleep_in = 1'b0;
        @(posedge clk); #1;
        check_out("R7 release one edge still off", 1023, 1'b1);
        @(posedge clk); #1;
        check_out("R7 release restores", 1023, 1'b0);
    endtask

    // R9: constant input keeps outputs steady for several cycles.
    task automatic t_hold();
        apply(345, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check_out("R9 hold", 345, 1'b0);
        end
    endtask

    // R8: reset during a stream returns to code 0.
    task automatic t_reset_mid();
        apply(555, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check_out("R8 mid-run reset", 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        code_in = 10'd555;
        @(posedge clk); #1;
        check_out("R8 first edge after reset", 0, 1'b0);
        @(posedge clk); #1;
        check_out("R1 after reset", 555, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL R1 watchdog: got no completion, expected finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_extremes();
        t_boundaries();
        t_latency();
        t_sweep();
        t_sleep();
        t_hold();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule